// File: doc/BRIEF.md
# Conversion Result Threshold Monitor

This block sits beside a converter's result slots and watches every result as it is written. Each of its two compare units is programmed with a channel select, a 12-bit unsigned threshold, a direction (below, or at-or-above) and a 4-bit match count. A qualifying result for the selected channel advances the unit's match counter. When the counter reaches the programmed count plus one, the unit raises a sticky flag. An optional interrupt follows the flag. Software clears the flag by writing 1 to it.

Unit 0 can also run in window mode. Its counter then advances only when both its own condition and unit 1's condition hold for the same result. The window condition is judged against unit 0's channel select. The two conditions together can bound a result from above and below.

Each unit is a three-state machine. In CMP_OFF the compare enable is low and the counter is held at zero. In CMP_TRACK the unit counts consecutive matches. In CMP_HELD the count has been reached and the flag is set, and no further counting happens until the flag is cleared. The transitions are:
- EN_ON: CMP_OFF to CMP_TRACK when the enable rises.
- HIT_LIMIT: CMP_TRACK to CMP_HELD on the last match needed.
- CLEAR: CMP_HELD to CMP_TRACK on a write-1 clear.
- EN_OFF: CMP_TRACK or CMP_HELD to CMP_OFF when the enable falls.

Top module: `cmp_monitor`

## Requirements
- R1: Direction 0 (`uX_cond`=0) counts a match when the result is strictly below the threshold. Direction 1 counts a match when the result is greater than or equal to the threshold. Both compare as 12-bit unsigned values.
- R2: A unit's flag rises on the clock edge that registers the (limit+1)-th consecutive matching result for its selected channel, and not earlier. It is visible the cycle after the strobe.
- R3: A result for the selected channel that does not match resets the match counter to 0.
- R4: Channel select codes 0 to 15 pick channels 0 to 15, and code 29 picks the internal reference channel. Results on other channels leave the counter untouched. A reserved select code (16 to 28, 30, 31) never matches any result.
- R5: A flag stays set through later results until its clear input is pulsed high for one cycle. The clear takes effect on that edge.
- R6: Each interrupt output is high exactly while its flag is set and its interrupt enable is high.
- R7: Lowering a unit's compare enable resets its match counter. Counting restarts from zero after the enable is raised again.
- R8: With `u0_win`=1, unit 0 counts only results on which both unit 0's condition and unit 1's condition (unit 1's threshold and direction) hold. This applies whatever unit 1's enable is. Unit 1 keeps working independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | Result written strobe |
| res_ch | input | 5 | Channel of the written result |
| res_data | input | 12 | Written result value |
| u0_en | input | 1 | Unit 0 compare enable |
| u0_ie | input | 1 | Unit 0 interrupt enable |
| u0_cond | input | 1 | Unit 0 direction (0 below, 1 at-or-above) |
| u0_win | input | 1 | Unit 0 window mode |
| u0_ch | input | 5 | Unit 0 channel select |
| u0_limit | input | 4 | Unit 0 match count (flag at limit+1) |
| u0_thr | input | 12 | Unit 0 threshold |
| u0_clr | input | 1 | Unit 0 flag write-1 clear |
| u1_en | input | 1 | Unit 1 compare enable |
| u1_ie | input | 1 | Unit 1 interrupt enable |
| u1_cond | input | 1 | Unit 1 direction |
| u1_ch | input | 5 | Unit 1 channel select |
| u1_limit | input | 4 | Unit 1 match count |
| u1_thr | input | 12 | Unit 1 threshold |
| u1_clr | input | 1 | Unit 1 flag write-1 clear |
| flag0 | output | 1 | Unit 0 sticky compare flag |
| flag1 | output | 1 | Unit 1 sticky compare flag |
| irq0 | output | 1 | Unit 0 interrupt |
| irq1 | output | 1 | Unit 1 interrupt |

## Verification
The match counter cannot be seen at the ports, so every counter effect is shown through the flag. A counter reset by a miss or by a disable only shows up as a flag that fails to appear after one fewer than the needed matches. The flag then appears after exactly the needed number of further matches. The stimulus builds a partial count, applies the disturbing event, and then walks the count up one result at a time, checking the flag after each step. Window mode is reached by programming the two units with opposite directions around a band. Results are then sent inside the band, below it and above it.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_TRACK = 2'd1,
        CMP_HELD  = 2'd2
    } cmp_state_t;
endpackage

// File: rtl/cmp_cond.sv
module cmp_cond #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5,
    parameter int NUM_CH = 16,
    parameter int REF_CH = 29
) (
    input  logic [CH_W-1:0]   res_ch,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   sel_ch,
    input  logic [DATA_W-1:0] thr,
    input  logic              cond,
    output logic              sel_hit,
    output logic              cond_hit
);
    logic code_legal;

    always_comb begin
        code_legal = (32'(sel_ch) < NUM_CH) || (32'(sel_ch) == REF_CH);
        sel_hit    = code_legal && (res_ch == sel_ch);
        cond_hit   = cond ? (res_data >= thr) : (res_data < thr);
    end
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import cmp_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter bit WIN_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ie,
    input  logic             win_en,
    input  logic [CNT_W-1:0] limit,
    input  logic             vld,
    input  logic             sel_hit,
    input  logic             own_hit,
    input  logic             partner_hit,
    input  logic             clr,
    output logic             flag,
    output logic             irq
);
    cmp_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             flag_nxt;
    logic             match;
    logic             sample;

    always_comb begin
        match  = (WIN_OK && win_en) ? (own_hit && partner_hit) : own_hit;
        sample = vld && sel_hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CMP_OFF;
            cnt   <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            flag  <= flag_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        flag_nxt  = clr ? 1'b0 : flag;
        unique case (state)
            CMP_OFF: begin
                cnt_nxt = '0;
                if (en) state_nxt = CMP_TRACK;
            end
            CMP_TRACK: begin
                if (!en) begin
                    state_nxt = CMP_OFF;
                    cnt_nxt   = '0;
                end else if (sample) begin
                    if (!match) begin
                        cnt_nxt = '0;
                    end else if (cnt >= limit) begin
                        state_nxt = CMP_HELD;
                        cnt_nxt   = '0;
                        flag_nxt  = 1'b1;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            CMP_HELD: begin
                cnt_nxt = '0;
                if (!en) state_nxt = CMP_OFF;
                else if (clr) state_nxt = CMP_TRACK;
            end
            default: begin
                state_nxt = CMP_OFF;
                cnt_nxt   = '0;
            end
        endcase
        irq = flag && ie;
    end

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(vld && sel_hit && en));

    assert_miss_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMP_TRACK && en && vld && sel_hit && !match) |=> (cnt == '0));
endmodule

// File: rtl/cmp_monitor.sv
module cmp_monitor #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 4,
    parameter int NUM_CH = 16,
    parameter int REF_CH = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [DATA_W-1:0] res_data,
    input  logic              u0_en,
    input  logic              u0_ie,
    input  logic              u0_cond,
    input  logic              u0_win,
    input  logic [CH_W-1:0]   u0_ch,
    input  logic [CNT_W-1:0]  u0_limit,
    input  logic [DATA_W-1:0] u0_thr,
    input  logic              u0_clr,
    input  logic              u1_en,
    input  logic              u1_ie,
    input  logic              u1_cond,
    input  logic [CH_W-1:0]   u1_ch,
    input  logic [CNT_W-1:0]  u1_limit,
    input  logic [DATA_W-1:0] u1_thr,
    input  logic              u1_clr,
    output logic              flag0,
    output logic              flag1,
    output logic              irq0,
    output logic              irq1
);
    localparam int NUM_U = 2;

    logic [NUM_U-1:0]             en_a, ie_a, cond_a, win_a, clr_a;
    logic [NUM_U-1:0][CH_W-1:0]   ch_a;
    logic [NUM_U-1:0][CNT_W-1:0]  lim_a;
    logic [NUM_U-1:0][DATA_W-1:0] thr_a;
    logic [NUM_U-1:0]             sel_a, hit_a, flag_a, irq_a;

    always_comb begin
        en_a   = {u1_en, u0_en};
        ie_a   = {u1_ie, u0_ie};
        cond_a = {u1_cond, u0_cond};
        win_a  = {1'b0, u0_win};
        clr_a  = {u1_clr, u0_clr};
        ch_a   = {u1_ch, u0_ch};
        lim_a  = {u1_limit, u0_limit};
        thr_a  = {u1_thr, u0_thr};
    end

    for (genvar i = 0; i < NUM_U; i++) begin : g_unit
        cmp_cond #(
            .DATA_W(DATA_W), .CH_W(CH_W), .NUM_CH(NUM_CH), .REF_CH(REF_CH)
        ) cond_i (
            .res_ch   (res_ch),
            .res_data (res_data),
            .sel_ch   (ch_a[i]),
            .thr      (thr_a[i]),
            .cond     (cond_a[i]),
            .sel_hit  (sel_a[i]),
            .cond_hit (hit_a[i])
        );

        cmp_unit #(
            .CNT_W(CNT_W), .WIN_OK(i == 0)
        ) unit_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (en_a[i]),
            .ie          (ie_a[i]),
            .win_en      (win_a[i]),
            .limit       (lim_a[i]),
            .vld         (res_vld),
            .sel_hit     (sel_a[i]),
            .own_hit     (hit_a[i]),
            .partner_hit (hit_a[NUM_U-1-i]),
            .clr         (clr_a[i]),
            .flag        (flag_a[i]),
            .irq         (irq_a[i])
        );
    end

    assign flag0 = flag_a[0];
    assign flag1 = flag_a[1];
    assign irq0  = irq_a[0];
    assign irq1  = irq_a[1];
endmodule

// File: tb/cmp_monitor_tb_top.sv
module cmp_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_vld = 1'b0;
    logic [4:0] res_ch = '0;
    logic [11:0] res_data = '0;
    logic u0_en = 0, u0_ie = 0, u0_cond = 0, u0_win = 0, u0_clr = 0;
    logic [4:0] u0_ch = '0;
    logic [3:0] u0_limit = '0;
    logic [11:0] u0_thr = '0;
    logic u1_en = 0, u1_ie = 0, u1_cond = 0, u1_clr = 0;
    logic [4:0] u1_ch = '0;
    logic [3:0] u1_limit = '0;
    logic [11:0] u1_thr = '0;
    logic flag0, flag1, irq0, irq1;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cmp_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch), .res_data(res_data),
        .u0_en(u0_en), .u0_ie(u0_ie), .u0_cond(u0_cond), .u0_win(u0_win), .u0_ch(u0_ch),
        .u0_limit(u0_limit), .u0_thr(u0_thr), .u0_clr(u0_clr),
        .u1_en(u1_en), .u1_ie(u1_ie), .u1_cond(u1_cond), .u1_ch(u1_ch),
        .u1_limit(u1_limit), .u1_thr(u1_thr), .u1_clr(u1_clr),
        .flag0(flag0), .flag1(flag1), .irq0(irq0), .irq1(irq1)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one result strobe; returns at the negedge after the registering edge
    task automatic send(input logic [4:0] ch, input logic [11:0] d);
        @(negedge clk);
        res_vld = 1'b1; res_ch = ch; res_data = d;
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic clear0();
        @(negedge clk); u0_clr = 1'b1;
        @(negedge clk); u0_clr = 1'b0;
    endtask

    task automatic clear1();
        @(negedge clk); u1_clr = 1'b1;
        @(negedge clk); u1_clr = 1'b0;
    endtask

    task automatic setup0(input logic cond, input logic [4:0] ch,
                          input logic [3:0] lim, input logic [11:0] thr);
        @(negedge clk);
        u0_en = 1'b0;
        @(negedge clk);
        u0_cond = cond; u0_ch = ch; u0_limit = lim; u0_thr = thr; u0_en = 1'b1;
        @(negedge clk);
        clear0();
    endtask

    task automatic t_reset();
        check("R5 reset flag0", flag0, 1'b0);
        check("R5 reset flag1", flag1, 1'b0);
        check("R6 reset irq0", irq0, 1'b0);
    endtask

    task automatic t_below_count();
        setup0(1'b0, 5'd3, 4'd2, 12'h400);
        u0_ie = 1'b1;
        send(5'd3, 12'h3FF);
        check("R2 after 1 match", flag0, 1'b0);
        send(5'd3, 12'h000);
        check("R2 after 2 matches", flag0, 1'b0);
        check("R6 irq quiet", irq0, 1'b0);
        send(5'd3, 12'h100);
        check("R2 flag on 3rd match", flag0, 1'b1);
        check("R6 irq with flag", irq0, 1'b1);
    endtask

    task automatic t_miss_reset();
        setup0(1'b0, 5'd3, 4'd2, 12'h400);
        send(5'd3, 12'h010);
        send(5'd3, 12'h020);
        send(5'd3, 12'h400);
        check("R1 equal is not below", flag0, 1'b0);
        send(5'd3, 12'h010);
        send(5'd3, 12'h010);
        check("R3 count restarted", flag0, 1'b0);
        send(5'd3, 12'h010);
        check("R3 flag after 3 fresh", flag0, 1'b1);
    endtask

    task automatic t_at_or_above();
        setup0(1'b1, 5'd7, 4'd0, 12'h800);
        send(5'd7, 12'h7FF);
        check("R1 below fails cond1", flag0, 1'b0);
        send(5'd7, 12'h800);
        check("R1 equal matches cond1", flag0, 1'b1);
    endtask

    task automatic t_channels();
        setup0(1'b1, 5'd5, 4'd1, 12'h100);
        send(5'd5, 12'h200);
        send(5'd6, 12'h000);
        check("R4 other ch no flag", flag0, 1'b0);
        send(5'd5, 12'h200);
        check("R4 other ch kept count", flag0, 1'b1);
        setup0(1'b1, 5'd20, 4'd0, 12'h000);
        send(5'd20, 12'hFFF);
        check("R4 reserved code never matches", flag0, 1'b0);
        setup0(1'b1, 5'd29, 4'd0, 12'h000);
        send(5'd29, 12'h001);
        check("R4 reference channel 29", flag0, 1'b1);
    endtask

    task automatic t_sticky();
        setup0(1'b1, 5'd1, 4'd0, 12'h100);
        u0_ie = 1'b1;
        send(5'd1, 12'h200);
        send(5'd1, 12'h000);
        check("R5 flag holds on miss", flag0, 1'b1);
        @(negedge clk); u0_ie = 1'b0;
        @(negedge clk);
        check("R6 irq off with ie low", irq0, 1'b0);
        check("R5 flag still set", flag0, 1'b1);
        clear0();
        check("R5 clear works", flag0, 1'b0);
    endtask

    task automatic t_disable();
        setup0(1'b1, 5'd2, 4'd1, 12'h100);
        send(5'd2, 12'h300);
        @(negedge clk); u0_en = 1'b0;
        @(negedge clk); u0_en = 1'b1;
        @(negedge clk);
        send(5'd2, 12'h300);
        check("R7 count reset by disable", flag0, 1'b0);
        send(5'd2, 12'h300);
        check("R7 flag after restart", flag0, 1'b1);
    endtask

    task automatic t_window();
        @(negedge clk);
        u1_en = 1'b0; u1_cond = 1'b1; u1_thr = 12'h100; u1_ch = 5'd9; u1_limit = 4'd0;
        setup0(1'b0, 5'd4, 4'd0, 12'h900);
        @(negedge clk); u0_win = 1'b1;
        send(5'd4, 12'h050);
        check("R8 below band no flag", flag0, 1'b0);
        send(5'd4, 12'hA00);
        check("R8 above band no flag", flag0, 1'b0);
        send(5'd4, 12'h500);
        check("R8 inside band flag", flag0, 1'b1);
        @(negedge clk); u0_win = 1'b0;
    endtask

    task automatic t_unit1();
        @(negedge clk);
        u1_en = 1'b1; u1_ie = 1'b1; u1_cond = 1'b0; u1_thr = 12'h080; u1_ch = 5'd15; u1_limit = 4'd1;
        clear1();
        send(5'd15, 12'h010);
        check("R2 unit1 1st match", flag1, 1'b0);
        send(5'd15, 12'h010);
        check("R2 unit1 2nd match flag", flag1, 1'b1);
        check("R6 unit1 irq", irq1, 1'b1);
        clear1();
        check("R5 unit1 clear", flag1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_below_count();
        t_miss_reset();
        t_at_or_above();
        t_channels();
        t_sticky();
        t_disable();
        t_window();
        t_unit1();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule